// File: doc/BRIEF.md
# Refresh Debt Scheduler

This block tells a DRAM command arbiter when an auto-refresh is owed. A free-running interval timer marks one nominal refresh period (derived from the clock frequency and the average refresh spacing the memory demands). Each period adds one refresh to a debt counter. While any refresh is owed and the memory is not recovering from a previous one, the block raises a low-priority request, so the arbiter can defer refreshes behind busy traffic. When the debt reaches the postponement limit (eight by default), the request turns urgent and the arbiter must grant a refresh next.

A grant taken while the request is up counts as a refresh command issued in that cycle. From then on the block marks the recovery window, during which the arbiter may issue no command, and asks for the clock-enable pin to stay high from the issuing cycle to the end of recovery. The memory generates the row address itself, so no address leaves the block, and self-refresh is not handled here.

Top module: `refresh_sched`

## Requirements
- R1: After reset, an interval tick occurs at every INTERVAL_CYC-th rising edge; each tick adds one to `owed`, unless a refresh is accepted at the same edge, in which case `owed` is unchanged.
- R2: `ref_req` is high exactly when `owed` is at least 1 and `ref_busy` is low.
- R3: `owed` never exceeds MAX_POSTPONE (8 by default); a tick arriving at the limit with no accepted refresh leaves it at the limit.
- R4: `ref_urgent` is high exactly when `owed` equals MAX_POSTPONE and `ref_busy` is low.
- R5: A cycle with `ref_gnt` and `ref_req` both high is an accepted refresh; at the next edge `owed` falls by one (absent a tick).
- R6: `ref_gnt` while `ref_req` is low has no effect: `owed` is unchanged apart from ticks and no recovery window starts.
- R7: After an accepted refresh, `ref_busy` is high for exactly TRFC_CYC cycles, beginning in the cycle after the grant.
- R8: `cke_hold` is high in the cycle of an accepted refresh and in every cycle `ref_busy` is high, and low otherwise.
- R9: While `rst_n` is low, `owed` is 0, all outputs are low, and the interval timer restarts from zero when reset is released.
- R10: INTERVAL_CYC is floor(CLK_MHZ*REFI_NS/1000), never longer than the required average spacing (976 for 125 MHz and 7812 ns); TRFC_CYC is ceil(CLK_MHZ*TRFC_NS/1000) (9 for 70 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter issues the refresh this cycle (honoured only while `ref_req` is high) |
| ref_req | output | 1 | At least one refresh owed and memory not recovering |
| ref_urgent | output | 1 | Debt at the postponement limit; must be granted next |
| ref_busy | output | 1 | Refresh recovery window; no command may issue |
| cke_hold | output | 1 | Clock enable must be held high |
| owed | output | PEND_W | Number of refreshes currently owed |

## Verification
The bench starves the arbiter until the debt saturates and keeps ticking, which a design without a limit guard would wrap past eight or to zero. It grants inside the recovery window and while nothing is owed, where a design that honoured stray grants would lose debt or restart the window. It counts cycles from reset to the first tick and to the end of recovery, catching an off-by-one interval or window, and drives grant and tick in the same cycle, where a wrong net update would drift the debt. A reset in mid-run confirms the interval timer restarts.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   // Request level seen by the command arbiter.
   typedef enum logic [1:0] {
      LVL_NONE   = 2'd0,
      LVL_LOW    = 2'd1,
      LVL_URGENT = 2'd2
   } req_level_t;

   // Cycles per nominal interval, rounded down so the spacing never exceeds the limit.
   function automatic int cycles_floor(input int mhz, input int ns);
      return (mhz * ns) / 1000;
   endfunction

   // Cycles covering a minimum time, rounded up.
   function automatic int cycles_ceil(input int mhz, input int ns);
      return (mhz * ns + 999) / 1000;
   endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
   parameter int INTERVAL_CYC = 976,
   localparam int CNT_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);

   // Ticks are never back to back for an interval of two or more cycles.
   p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt
   import refsched_pkg::*;
#(
   parameter int MAX_POSTPONE = 8,
   localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gnt,
   input  logic              busy,
   output logic [PEND_W-1:0] owed,
   output req_level_t        level,
   output logic              accept
);
   localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_POSTPONE);

   logic [PEND_W-1:0] owed_q, owed_d;

   always_comb begin
      if (busy || owed_q == '0)
         level = LVL_NONE;
      else if (owed_q == LIMIT)
         level = LVL_URGENT;
      else
         level = LVL_LOW;
   end

   assign accept = gnt && (level != LVL_NONE);

   always_comb begin
      owed_d = owed_q;
      unique case ({tick, accept})
         2'b10:   if (owed_q != LIMIT) owed_d = owed_q + 1'b1;
         2'b01:   owed_d = owed_q - 1'b1;
         default: owed_d = owed_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owed_q <= '0;
      else
         owed_q <= owed_d;
   end

   assign owed = owed_q;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q <= LIMIT);

   p_accept_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !tick) |=> (owed_q == $past(owed_q) - 1'b1));

   p_stray_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && !accept && !tick) |=> $stable(owed_q));

   p_tick_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !accept && owed_q != LIMIT) |=> (owed_q == $past(owed_q) + 1'b1));

endmodule

// File: rtl/refsched_recovery.sv
module refsched_recovery #(
   parameter int TRFC_CYC = 9,
   localparam int RW = $clog2(TRFC_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (TRFC_CYC == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start;
         end
         assign busy = busy_q;
      end else begin : g_count
         logic [RW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (start)
               left_q <= RW'(TRFC_CYC);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate

   p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refsched_pkg::*;
#(
   parameter int CLK_MHZ      = 125,
   parameter int REFI_NS      = 7812,
   parameter int TRFC_NS      = 70,
   parameter int MAX_POSTPONE = 8,
   localparam int PEND_W = $clog2(MAX_POSTPONE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_gnt,
   output logic              ref_req,
   output logic              ref_urgent,
   output logic              ref_busy,
   output logic              cke_hold,
   output logic [PEND_W-1:0] owed
);
   localparam int INTERVAL_CYC = cycles_floor(CLK_MHZ, REFI_NS);
   localparam int TRFC_CYC     = cycles_ceil(CLK_MHZ, TRFC_NS);

   generate
      if (MAX_POSTPONE < 1) begin : g_bad_limit
         $error("MAX_POSTPONE must be at least 1");
      end
      if (INTERVAL_CYC < 2) begin : g_bad_interval
         $error("refresh interval must span at least two clocks");
      end
      if (TRFC_CYC < 1 || TRFC_CYC >= INTERVAL_CYC) begin : g_bad_trfc
         $error("recovery time must be nonzero and shorter than the interval");
      end
   endgenerate

   logic       tick;
   logic       accept;
   req_level_t level;

   refsched_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   refsched_debt #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .gnt   (ref_gnt),
      .busy  (ref_busy),
      .owed  (owed),
      .level (level),
      .accept(accept)
   );

   refsched_recovery #(.TRFC_CYC(TRFC_CYC)) u_recovery (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .busy (ref_busy)
   );

   assign ref_req    = (level != LVL_NONE);
   assign ref_urgent = (level == LVL_URGENT);
   assign cke_hold   = ref_busy || accept;

   p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> !ref_req);

   p_urgent_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> (ref_req && owed == PEND_W'(MAX_POSTPONE)));

   p_cke_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_busy || (ref_gnt && ref_req)) |-> cke_hold);

   p_no_cmd_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |=> !$rose(ref_req) || !$past(ref_busy) || !ref_busy);

endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
   localparam int INT_CYC = (125 * 7812) / 1000;     // R10: 976
   localparam int TRFC    = (125 * 70 + 999) / 1000; // R10: 9
   localparam int LIM     = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ref_gnt;
   logic       ref_req, ref_urgent, ref_busy, cke_hold;
   logic [3:0] owed;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int m_phase, m_owed, m_left;

   always #4 clk = ~clk;

   refresh_sched dut (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
      .cke_hold(cke_hold), .owed(owed)
   );

   function automatic bit m_req();
      return (m_owed > 0) && (m_left == 0);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit acc, tk;
         acc = ref_gnt && m_req();
         tk  = (m_phase == INT_CYC - 1);
         m_phase = tk ? 0 : m_phase + 1;
         m_owed  = m_owed + (tk ? 1 : 0) - (acc ? 1 : 0);
         if (m_owed > LIM) m_owed = LIM;
         if (acc) m_left = TRFC;
         else if (m_left > 0) m_left = m_left - 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic compare();
      bit e_req, e_urg, e_busy, e_cke;
      e_req  = rst_n && m_req();
      e_urg  = rst_n && m_req() && (m_owed == LIM);
      e_busy = rst_n && (m_left > 0);
      e_cke  = e_busy || (e_req && ref_gnt);
      chk(ref_req == e_req,     "R2 ref_req",    ref_req,    e_req);
      chk(ref_urgent == e_urg,  "R4 ref_urgent", ref_urgent, e_urg);
      chk(ref_busy == e_busy,   "R7 ref_busy",   ref_busy,   e_busy);
      chk(cke_hold == e_cke,    "R8 cke_hold",   cke_hold,   e_cke);
      chk(int'(owed) == m_owed, "R1/R3/R5/R6 owed", owed,    m_owed);
   endtask

   logic [15:0] lfsr = 16'hACE1;
   int cyc = 0;
   int first_tick = -1;

   // mode 0 starve, 1 greedy, 2 urgent only, 3 pseudo-random incl. stray grants
   task automatic run(input int mode, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc++;
         compare();
         if (first_tick < 0 && owed == 4'd1) first_tick = cyc;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (mode)
            0: ref_gnt = 1'b0;
            1: ref_gnt = ref_req;
            2: ref_gnt = ref_urgent;
            default: ref_gnt = ref_urgent | (lfsr[2:0] == 3'd0);
         endcase
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ref_gnt = 1'b0;
      m_phase = 0; m_owed = 0; m_left = 0;
      repeat (3) begin
         @(negedge clk);
         chk(!ref_req && !ref_urgent && !ref_busy && !cke_hold && owed == 0,
             "R9 reset outputs", {ref_req, ref_urgent, ref_busy, cke_hold, owed}, 0);
      end
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; ref_gnt = 1'b0;
      m_phase = 0; m_owed = 0; m_left = 0;
      do_reset();
      cyc = 0;
      // starve: debt climbs and saturates at the limit (R3)
      run(0, INT_CYC * 10 + 5);
      chk(first_tick == INT_CYC, "R10 first tick cycle", first_tick, INT_CYC);
      chk(owed == 4'(LIM), "R3 saturated debt", owed, LIM);
      chk(ref_urgent == 1'b1, "R4 urgent at limit", ref_urgent, 1);
      // single grant, then stray grants during recovery (R6, R7)
      @(negedge clk); ref_gnt = 1'b1;
      @(negedge clk);
      chk(ref_busy == 1'b1 && owed == 4'(LIM - 1), "R5 grant accepted", owed, LIM - 1);
      m_owed = m_owed; // model already advanced
      ref_gnt = 1'b1;
      for (int k = 1; k < TRFC; k++) begin
         @(negedge clk);
         chk(ref_busy == 1'b1 && owed == 4'(LIM - 1), "R6 stray grant in window", owed, LIM - 1);
      end
      @(negedge clk);
      chk(ref_busy == 1'b0, "R7 window length", ref_busy, 0);
      ref_gnt = 1'b0;
      @(negedge clk);
      // greedy drain
      run(1, 300);
      chk(owed == 0, "R5 drained", owed, 0);
      run(1, INT_CYC * 3);
      run(2, INT_CYC * 12);
      run(3, 20000);
      // mid-run reset restarts the interval timer (R9)
      do_reset();
      first_tick = -1; cyc = 0;
      run(0, INT_CYC + 2);
      chk(first_tick == INT_CYC, "R9 timer restart", first_tick, INT_CYC);
      run(3, 5000);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule